// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This peripheral gives a processor three byte-wide ports, named A, B and C. Port C is handled as two independent nibbles. The processor reaches the block through a synchronous bus: chip select, read and write strobes, a two-bit address and an 8-bit data bus. Every access completes in one clock cycle. Each of the four port groups (A, B, C upper, C lower) can be set as an input or an output. Outputs come from held latches. Inputs are read live from the pins.

One control address accepts two kinds of command, and bit 7 of the written byte selects between them. A mode word (bit 7 = 1) sets the direction of all four groups. It also clears the output latches and every interrupt-enable flop. A single-bit command (bit 7 = 0) sets or clears one port C latch bit and the interrupt-enable flop with the same index. The strobed and bidirectional handshake modes are not implemented. A mode word that requests them is applied as basic I/O, and a status output flags it.

Top module: `pio_ctrl`

## Requirements
- R1: After reset all four groups are inputs (every output enable low), all latches read 0, every interrupt enable is 0, the unsupported-mode flag is 0 and read data is 0.
- R2: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register. A write to address 0, 1 or 2 loads that port's latch. A read of address 3 returns 0xFF.
- R3: No access has any effect while chip select is low.
- R4: A mode word (control write with bit 7 = 1) sets the group directions from four bits, with 1 meaning input and 0 meaning output: bit 4 for port A, bit 3 for C upper, bit 1 for port B and bit 0 for C lower. Each group's output enable is high exactly when that group is an output.
- R5: A mode word clears all three output latches to 0.
- R6: A port read returns the latch for a group configured as output and the live pins for a group configured as input. Each port C nibble follows its own direction.
- R7: A control write with bit 7 = 0 is a single-bit command. Bits 3..1 give the port C bit index and bit 0 gives the new value (1 = set, 0 = clear). Only that latch bit changes, and bits 6..4 are ignored.
- R8: The same single-bit command writes its value into the interrupt-enable flop at that index and leaves the other flops unchanged.
- R9: A mode word clears every interrupt-enable flop.
- R10: A mode word with any of bits 6, 5 or 2 set raises the unsupported-mode flag and is still applied as basic I/O. A mode word with all three bits clear lowers the flag.
- R11: Read data is registered. It appears the cycle after a selected read and holds its value until the next selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch |
| pcu_oe | output | 1 | Port C upper nibble output enable |
| pcl_oe | output | 1 | Port C lower nibble output enable |
| int_en | output | 8 | Interrupt-enable flops, indexed by port C bit |
| mode_unsup | output | 1 | A mode word asked for an unsupported mode |

## Verification
The assertions check the following on every cycle. A mode word sets the directions and clears the interrupt enables and latches. A single-bit command changes at most its indexed latch bit. A deselected cycle leaves state unchanged. A control read returns 0xFF, and read data holds between reads. Only the bench scenarios can show the rest, because it depends on pin values and on a chain of earlier commands. That covers the per-nibble read mux combining live pins with latch bits, the ignored bits 6..4 of a single-bit command, and the flag's set and clear sequence.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // direction flags, 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pio_dec.sv
module pio_dec #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic             cs,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic             cmd_kind,
  input  logic [IDX_W:0]   cmd_low,
  output logic             wr_a,
  output logic             wr_b,
  output logic             wr_c,
  output logic             mode_wr,
  output logic             bsr_wr,
  output logic [IDX_W-1:0] bsr_idx,
  output logic             bsr_val
);
  import pio_pkg::*;

  logic sel_wr;
  assign sel_wr  = cs && wr;
  assign wr_a    = sel_wr && (sel_e'(addr) == SEL_A);
  assign wr_b    = sel_wr && (sel_e'(addr) == SEL_B);
  assign wr_c    = sel_wr && (sel_e'(addr) == SEL_C);
  assign mode_wr = sel_wr && (sel_e'(addr) == SEL_CTRL) && cmd_kind;
  assign bsr_wr  = sel_wr && (sel_e'(addr) == SEL_CTRL) && !cmd_kind;
  assign bsr_idx = cmd_low[IDX_W:1];
  assign bsr_val = cmd_low[0];
endmodule

// File: rtl/pio_cfg.sv
module pio_cfg #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [6:0]       mode_bits,
  input  logic             bsr_wr,
  input  logic [IDX_W-1:0] bsr_idx,
  input  logic             bsr_val,
  output pio_pkg::dir_t    dir,
  output logic [DW-1:0]    inte,
  output logic             unsup
);
  localparam int A_BIT  = 4;
  localparam int CU_BIT = 3;
  localparam int B_BIT  = 1;
  localparam int CL_BIT = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir   <= '1;
      inte  <= '0;
      unsup <= 1'b0;
    end else if (mode_wr) begin
      dir.a_in  <= mode_bits[A_BIT];
      dir.cu_in <= mode_bits[CU_BIT];
      dir.b_in  <= mode_bits[B_BIT];
      dir.cl_in <= mode_bits[CL_BIT];
      inte      <= '0;
      unsup     <= mode_bits[6] | mode_bits[5] | mode_bits[2];
    end else if (bsr_wr) begin
      inte[bsr_idx] <= bsr_val;
    end
  end

  // R4
  dir_map_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (dir.a_in == $past(mode_bits[A_BIT])) &&
                (dir.cu_in == $past(mode_bits[CU_BIT])) &&
                (dir.b_in == $past(mode_bits[B_BIT])) &&
                (dir.cl_in == $past(mode_bits[CL_BIT])));
  // R9
  inte_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (inte == '0));
  // R8
  inte_single_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> ($countones(inte ^ $past(inte)) <= 1));
endmodule

// File: rtl/pio_latches.sv
module pio_latches #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic             wr_c,
  input  logic             mode_wr,
  input  logic             bsr_wr,
  input  logic [IDX_W-1:0] bsr_idx,
  input  logic             bsr_val,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    a_q,
  output logic [DW-1:0]    b_q,
  output logic [DW-1:0]    c_q
);
  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      if (wr_a) a_q <= din;
      if (wr_b) b_q <= din;
      if (wr_c) c_q <= din;
      else if (bsr_wr) c_q[bsr_idx] <= bsr_val;
    end
  end

  // R7
  bsr_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> ($countones(c_q ^ $past(c_q)) <= 1) &&
               (c_q[$past(bsr_idx)] == $past(bsr_val)));
  // R5
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (a_q == '0) && (b_q == '0) && (c_q == '0));
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic          pcu_oe,
  output logic          pcl_oe,
  output logic [DW-1:0] int_en,
  output logic          mode_unsup
);
  import pio_pkg::*;

  localparam int IDX_W = $clog2(DW);
  localparam int HW    = DW / 2;

  logic             wr_a, wr_b, wr_c, mode_wr, bsr_wr, bsr_val;
  logic [IDX_W-1:0] bsr_idx;
  dir_t             dir;
  logic [DW-1:0]    a_q, b_q, c_q;
  logic [DW-1:0]    c_view;

  pio_dec #(.DW(DW), .IDX_W(IDX_W)) dec_i (
    .cs(cs), .wr(wr), .addr(addr),
    .cmd_kind(din[DW-1]), .cmd_low(din[IDX_W:0]),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .mode_wr(mode_wr), .bsr_wr(bsr_wr),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  pio_cfg #(.DW(DW), .IDX_W(IDX_W)) cfg_i (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_bits(din[6:0]),
    .bsr_wr(bsr_wr), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
    .dir(dir), .inte(int_en), .unsup(mode_unsup)
  );

  pio_latches #(.DW(DW), .IDX_W(IDX_W)) lat_i (
    .clk(clk), .rst(rst),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .mode_wr(mode_wr), .bsr_wr(bsr_wr),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val), .din(din),
    .a_q(a_q), .b_q(b_q), .c_q(c_q)
  );

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = !dir.a_in;
  assign pb_oe  = !dir.b_in;
  assign pcu_oe = !dir.cu_in;
  assign pcl_oe = !dir.cl_in;

  assign c_view = {dir.cu_in ? pc_in[DW-1:HW] : c_q[DW-1:HW],
                   dir.cl_in ? pc_in[HW-1:0]  : c_q[HW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (cs && rd) begin
      case (sel_e'(addr))
        SEL_A:   dout <= dir.a_in ? pa_in : a_q;
        SEL_B:   dout <= dir.b_in ? pb_in : b_q;
        SEL_C:   dout <= c_view;
        default: dout <= '1;
      endcase
    end
  end

  // R3
  no_cs_effect_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
            $stable(int_en) && $stable(dout) && $stable(pa_oe));
  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'd3) |=> (dout == '1));
  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> $stable(dout));
endmodule

// File: tb/pio_ctrl_tb.sv
module pio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, pa_out, pb_out, pc_out, int_en;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic       pa_oe, pb_oe, pcu_oe, pcl_oe, mode_unsup;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pio_ctrl dut_i (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pcu_oe(pcu_oe), .pcl_oe(pcl_oe),
    .int_en(int_en), .mode_unsup(mode_unsup)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // monitor: compares registered read data one cycle after each selected read
  initial begin
    forever begin
      logic fired;
      @(posedge clk);
      fired = cs && rd && !rst;
      @(negedge clk);
      if (fired && exp_q.size() > 0) begin
        chk(dout, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h00, "R1 oe");
    chk(pa_out | pb_out | pc_out, 8'h00, "R1 latches");
    chk(int_en, 8'h00, "R1 int_en");
    chk({7'b0, mode_unsup}, 8'h00, "R1 unsup");
    chk(dout, 8'h00, "R1 dout");

    pa_in = 8'h3C;
    bus_rd(2'd0, 8'h3C, "R6 input live A");
    bus_rd(2'd3, 8'hFF, "R2 ctrl read");

    // all outputs
    bus_wr(1'b1, 2'd3, 8'h80);
    chk({4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h0F, "R4 all out");
    chk({7'b0, mode_unsup}, 8'h00, "R10 basic");
    bus_wr(1'b1, 2'd0, 8'h5A);
    bus_wr(1'b1, 2'd1, 8'hC3);
    bus_wr(1'b1, 2'd2, 8'h96);
    chk(pa_out, 8'h5A, "R2 A");
    chk(pb_out, 8'hC3, "R2 B");
    chk(pc_out, 8'h96, "R2 C");
    pb_in = 8'h11;
    bus_rd(2'd0, 8'h5A, "R6 latch A");
    bus_rd(2'd1, 8'hC3, "R6 latch B");

    // R3 deselected write
    bus_wr(1'b0, 2'd0, 8'hFF);
    bus_wr(1'b0, 2'd3, 8'h01);
    chk(pa_out, 8'h5A, "R3 A kept");
    chk(pc_out, 8'h96, "R3 C kept");
    chk(int_en, 8'h00, "R3 int_en kept");

    // R7/R8 single-bit commands
    bus_wr(1'b1, 2'd3, 8'h01);
    chk(pc_out, 8'h97, "R7 set bit0");
    chk(int_en, 8'h01, "R8 set 0");
    bus_wr(1'b1, 2'd3, 8'h78);
    chk(pc_out, 8'h87, "R7 clear bit4, bits 6..4 ignored");
    chk(int_en, 8'h01, "R8 clear 4");
    bus_wr(1'b1, 2'd3, 8'h0B);
    chk(pc_out, 8'hA7, "R7 set bit5");
    chk(int_en, 8'h21, "R8 set 5");
    chk(pa_out, 8'h5A, "R7 A untouched");

    // mixed directions: A in, Cu in, B in, Cl out
    bus_wr(1'b1, 2'd3, 8'h9A);
    chk(int_en, 8'h00, "R9 cleared");
    chk(pa_out | pb_out | pc_out, 8'h00, "R5 cleared");
    chk({4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h01, "R4 mixed");
    bus_wr(1'b1, 2'd2, 8'h5E);
    pc_in = 8'hA3;
    bus_rd(2'd2, 8'hAE, "R6 C nibbles");
    bus_rd(2'd1, 8'h11, "R6 input live B");

    // unsupported mode
    bus_wr(1'b1, 2'd3, 8'hE4);
    chk({7'b0, mode_unsup}, 8'h01, "R10 flag set");
    chk({4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h0F, "R10 basic dirs");
    chk(dout, 8'h11, "R11 hold");
    bus_wr(1'b1, 2'd3, 8'h80);
    chk({7'b0, mode_unsup}, 8'h00, "R10 flag clear");

    repeat (3) @(negedge clk);
    chk({7'b0, (exp_q.size() == 0)}, 8'h01, "R11 all reads seen");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule